// File: doc/BRIEF.md
# Instruction Fetch and Decode Front End

This block is the front end of a five-stage, 32-bit load/store pipeline. It owns the program counter, the fetch/decode pipeline register and a two-read-port register file. Each cycle it issues a fetch address and captures the instruction word returned for that address. It then classifies the captured word by its 6-bit opcode, extracts the register and immediate fields, reads both source registers and settles any conditional branch in the same decode cycle. A taken branch redirects the very next fetch, so no wrong-path word is ever captured.

There is no jump format. An unconditional jump is written as a branch-if-zero on register 0, which always reads as zero. The later pipeline stages write results back through a single write port. A register that is written in the same cycle it is read delivers the new value. A freeze input from the hazard logic outside holds the fetch state, but write-back continues.

Top module: `fdf_front`

## Requirements
- R1: While `rst_n` is 0, `pc_o` is all ones (0xFFFF for a 16-bit PC), `fetch_addr_o` is 0, `id_class_o` is 0 (no-op) and `br_taken_o` is 0. The first fetch after reset is therefore from address 0.
- R2: On a clock edge where `freeze` is 0 and no branch is taken, the PC advances by one word: `pc_o` becomes the old `pc_o + 1`, and `fetch_addr_o` is always `pc_o + 1` when no branch is taken. Arithmetic is modulo 2^PC_W.
- R3: `id_class_o` encodes the opcode `instr[31:26]` of the decoded word as follows: 000000 gives 0 (no-op), 010xxx gives 1 (load), 011xxx gives 2 (store), 100xxx gives 3 (register ALU), 11xxxx gives 4 (immediate ALU), 101xxx gives 5 (flow control), and any other opcode gives 6 (undefined).
- R4: The destination index `id_dst_o` takes a different field per class. For class 3 it is `[15:11]`. For classes 1 and 4 it is `[20:16]`. For every other class it is 0. `id_func_o` is always `[10:0]`.
- R5: `id_imm_o` is bits `[15:0]` sign-extended to XLEN bits.
- R6: A word of class 5 is a branch on the value of the register named by `[25:21]`. When bit 26 is 0 the branch is taken if that value is zero; when bit 26 is 1 it is taken if the value is non-zero. When taken, `br_taken_o` is 1 and `fetch_addr_o` is `pc_o + 1 + imm` (modulo 2^PC_W). That address becomes `pc_o` on the next unfrozen edge.
- R7: Register 0 reads as zero on both read ports, and a write-back to index 0 changes nothing.
- R8: The rs1 operand `id_rs1_val_o` (field `[25:21]`) and the rs2 operand `id_rs2_val_o` (field `[20:16]`) return the register contents. If `wb_en` is 1 and `wb_idx` matches a non-zero source index in the same cycle, that operand returns `wb_data` instead.
- R9: On an edge where `freeze` is 1, the PC and the decoded instruction keep their values, while the register write-back still takes effect.
- R10: An opcode-101 word with bit 26 = 0 and rs1 = 0 is always taken, acting as an unconditional jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Hold PC and decode register |
| instr_i | input | 32 | Instruction word at `fetch_addr_o` |
| wb_en | input | 1 | Write-back enable |
| wb_idx | input | 5 | Write-back register index |
| wb_data | input | XLEN | Write-back value |
| fetch_addr_o | output | PC_W | Address of the word to fetch this cycle |
| pc_o | output | PC_W | Address of the word in decode |
| id_class_o | output | 3 | Instruction class code |
| id_rs1_val_o | output | XLEN | First source operand |
| id_rs2_val_o | output | XLEN | Second source operand |
| id_dst_o | output | 5 | Destination register index |
| id_func_o | output | 11 | Function field |
| id_imm_o | output | XLEN | Sign-extended immediate |
| br_taken_o | output | 1 | Branch in decode is taken |

## Verification
The hardest case to reach is a branch whose condition depends on a write-back that arrives in the same cycle. It matters most when that write-back hits the tested register with zero, or targets register 0 with a non-zero value. The random stimulus keeps both register fields and the write-back index in a narrow range, writes zero about a quarter of the time and mixes in freeze cycles. Bypassed branch decisions, frozen branches and ignored writes to register 0 therefore occur many times. Directed steps add a backward jump on register 0 that wraps below address 0, a same-cycle bypass into a branch, and a reset in the middle of the run.

// File: rtl/fdf_pkg.sv
package fdf_pkg;

  localparam int INSTR_W = 32;
  localparam int RIDX_W  = 5;
  localparam int IMM_W   = 16;
  localparam int FUNC_W  = 11;

  localparam int OP_LSB   = 26;
  localparam int SRCA_LSB = 21;
  localparam int SRCB_LSB = 16;
  localparam int DSTR_LSB = 11;

  typedef enum logic [2:0] {
    CLS_NOP   = 3'd0,
    CLS_LOAD  = 3'd1,
    CLS_STORE = 3'd2,
    CLS_ALU_R = 3'd3,
    CLS_ALU_I = 3'd4,
    CLS_FLOW  = 3'd5,
    CLS_BAD   = 3'd6
  } instr_class_e;

  typedef struct packed {
    instr_class_e            cls;
    logic [RIDX_W-1:0]       src_a;
    logic [RIDX_W-1:0]       src_b;
    logic [RIDX_W-1:0]       dst;
    logic [FUNC_W-1:0]       func;
    logic [IMM_W-1:0]        imm;
    logic                    br_nz;
  } dec_fields_t;

endpackage

// File: rtl/fdf_pc.sv
module fdf_pc #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv_en,
  input  logic            take,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc_q,
  output logic [PC_W-1:0] fetch_addr
);

  logic [PC_W-1:0] seq_addr;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    seq_addr   = pc_q + PC_W'(1);
    fetch_addr = take ? target : seq_addr;
    pc_d       = adv_en ? fetch_addr : pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '1;
    end else begin
      pc_q <= pc_d;
    end
  end

endmodule

// File: rtl/fdf_regfile.sv
module fdf_regfile #(
  parameter int XLEN  = 32,
  parameter int AW    = 5,
  parameter int NREAD = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [AW-1:0]              waddr,
  input  logic [XLEN-1:0]            wdata,
  input  logic [NREAD-1:0][AW-1:0]   raddr,
  output logic [NREAD-1:0][XLEN-1:0] rdata
);

  localparam int NREGS = 1 << AW;

  logic [NREGS-1:0][XLEN-1:0] regs_q;
  logic [NREGS-1:0][XLEN-1:0] regs_d;
  logic                       wr_live;

  always_comb begin
    wr_live = we && (waddr != '0);
    regs_d  = regs_q;
    if (wr_live) begin
      regs_d[waddr] = wdata;
    end
    regs_d[0] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else begin
      regs_q <= regs_d;
    end
  end

  for (genvar p = 0; p < NREAD; p++) begin : g_rport
    always_comb begin
      if (raddr[p] == '0) begin
        rdata[p] = '0;
      end else if (wr_live && (waddr == raddr[p])) begin
        rdata[p] = wdata;
      end else begin
        rdata[p] = regs_q[raddr[p]];
      end
    end
  end

endmodule

// File: rtl/fdf_decode.sv
module fdf_decode
  import fdf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0] ir,
  output dec_fields_t        dec,
  output logic [XLEN-1:0]    imm_ext
);

  logic [5:0] opc;

  always_comb begin
    opc = ir[INSTR_W-1:OP_LSB];
    casez (opc)
      6'b000000: dec.cls = CLS_NOP;
      6'b010???: dec.cls = CLS_LOAD;
      6'b011???: dec.cls = CLS_STORE;
      6'b100???: dec.cls = CLS_ALU_R;
      6'b11????: dec.cls = CLS_ALU_I;
      6'b101???: dec.cls = CLS_FLOW;
      default:   dec.cls = CLS_BAD;
    endcase

    dec.src_a = ir[SRCA_LSB +: RIDX_W];
    dec.src_b = ir[SRCB_LSB +: RIDX_W];
    dec.func  = ir[FUNC_W-1:0];
    dec.imm   = ir[IMM_W-1:0];
    dec.br_nz = ir[OP_LSB];

    unique case (dec.cls)
      CLS_ALU_R:          dec.dst = ir[DSTR_LSB +: RIDX_W];
      CLS_LOAD, CLS_ALU_I: dec.dst = ir[SRCB_LSB +: RIDX_W];
      default:            dec.dst = '0;
    endcase

    imm_ext = {{(XLEN-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
  end

endmodule

// File: rtl/fdf_branch.sv
module fdf_branch
  import fdf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 16
) (
  input  instr_class_e    cls,
  input  logic            br_nz,
  input  logic [XLEN-1:0] src_val,
  input  logic [PC_W-1:0] pc,
  input  logic [XLEN-1:0] imm_ext,
  output logic            taken,
  output logic [PC_W-1:0] target
);

  logic is_zero;

  always_comb begin
    is_zero = (src_val == '0);
    taken   = (cls == CLS_FLOW) && (br_nz ? !is_zero : is_zero);
    target  = pc + PC_W'(1) + imm_ext[PC_W-1:0];
  end

endmodule

// File: rtl/fdf_front.sv
module fdf_front
  import fdf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [31:0]       instr_i,
  input  logic              wb_en,
  input  logic [4:0]        wb_idx,
  input  logic [XLEN-1:0]   wb_data,
  output logic [PC_W-1:0]   fetch_addr_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [2:0]        id_class_o,
  output logic [XLEN-1:0]   id_rs1_val_o,
  output logic [XLEN-1:0]   id_rs2_val_o,
  output logic [4:0]        id_dst_o,
  output logic [10:0]       id_func_o,
  output logic [XLEN-1:0]   id_imm_o,
  output logic              br_taken_o
);

  localparam int NRD = 2;

  logic [INSTR_W-1:0]           ir_q;
  logic [INSTR_W-1:0]           ir_d;
  logic                         adv_en;
  dec_fields_t                  dec;
  logic [XLEN-1:0]              imm_ext;
  logic [NRD-1:0][RIDX_W-1:0]   rd_idx;
  logic [NRD-1:0][XLEN-1:0]     rd_val;
  logic                         take;
  logic [PC_W-1:0]              target;

  assign adv_en = !freeze;

  always_comb begin
    ir_d = adv_en ? instr_i : ir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else begin
      ir_q <= ir_d;
    end
  end

  fdf_pc #(.PC_W(PC_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_en     (adv_en),
    .take       (take),
    .target     (target),
    .pc_q       (pc_o),
    .fetch_addr (fetch_addr_o)
  );

  fdf_decode #(.XLEN(XLEN)) u_dec (
    .ir      (ir_q),
    .dec     (dec),
    .imm_ext (imm_ext)
  );

  assign rd_idx[0] = dec.src_a;
  assign rd_idx[1] = dec.src_b;

  fdf_regfile #(.XLEN(XLEN), .AW(RIDX_W), .NREAD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wb_en),
    .waddr (wb_idx),
    .wdata (wb_data),
    .raddr (rd_idx),
    .rdata (rd_val)
  );

  fdf_branch #(.XLEN(XLEN), .PC_W(PC_W)) u_br (
    .cls     (dec.cls),
    .br_nz   (dec.br_nz),
    .src_val (rd_val[0]),
    .pc      (pc_o),
    .imm_ext (imm_ext),
    .taken   (take),
    .target  (target)
  );

  assign id_class_o   = dec.cls;
  assign id_rs1_val_o = rd_val[0];
  assign id_rs2_val_o = rd_val[1];
  assign id_dst_o     = dec.dst;
  assign id_func_o    = dec.func;
  assign id_imm_o     = imm_ext;
  assign br_taken_o   = take;

endmodule

// File: rtl/fdf_front_chk.sv
module fdf_front_chk #(
  parameter int XLEN = 32,
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            freeze,
  input logic [31:0]     ir_q,
  input logic            wb_en,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic [PC_W-1:0] pc_o,
  input logic [2:0]      id_class_o,
  input logic [XLEN-1:0] id_rs1_val_o,
  input logic [XLEN-1:0] id_imm_o,
  input logic            br_taken_o
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_pc_reset_R1: assert (pc_o == '1 && ir_q == '0 && !br_taken_o);
    end
  end

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !br_taken_o) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  assert_imm_sext_R5: assert property (@(posedge clk) disable iff (!rst_n)
    id_imm_o[XLEN-1:15] == '0 || id_imm_o[XLEN-1:15] == '1);

  assert_taken_flow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken_o |-> (ir_q[31:29] == 3'b101 && id_class_o == 3'd5));

  assert_r0_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[25:21] == 5'd0) |-> id_rs1_val_o == '0);

  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wb_idx != 5'd0 && wb_idx == ir_q[25:21]) |-> id_rs1_val_o == wb_data);

  assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> ($stable(pc_o) && $stable(ir_q)));

  assert_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_q[31:26] == 6'b101000 && ir_q[25:21] == 5'd0) |-> br_taken_o);

endmodule

bind fdf_front fdf_front_chk #(.XLEN(XLEN), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .freeze       (freeze),
  .ir_q         (ir_q),
  .wb_en        (wb_en),
  .wb_idx       (wb_idx),
  .wb_data      (wb_data),
  .pc_o         (pc_o),
  .id_class_o   (id_class_o),
  .id_rs1_val_o (id_rs1_val_o),
  .id_imm_o     (id_imm_o),
  .br_taken_o   (br_taken_o)
);

// File: tb/fdf_front_test.sv
`timescale 1ns/1ps
module fdf_front_test;

  localparam int XLEN = 32;
  localparam int PC_W = 16;

  logic            clk;
  logic            rst_n;
  logic            freeze;
  logic [31:0]     instr_i;
  logic            wb_en;
  logic [4:0]      wb_idx;
  logic [XLEN-1:0] wb_data;
  logic [PC_W-1:0] fetch_addr_o;
  logic [PC_W-1:0] pc_o;
  logic [2:0]      id_class_o;
  logic [XLEN-1:0] id_rs1_val_o;
  logic [XLEN-1:0] id_rs2_val_o;
  logic [4:0]      id_dst_o;
  logic [10:0]     id_func_o;
  logic [XLEN-1:0] id_imm_o;
  logic            br_taken_o;

  int checks;
  int errors;
  bit done;

  logic [XLEN-1:0] m_regs [32];
  logic [PC_W-1:0] m_pc;
  logic [31:0]     m_ir;

  fdf_front #(.XLEN(XLEN), .PC_W(PC_W)) uut (.*);

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [2:0] f_class(logic [31:0] w);
    logic [5:0] op;
    op = w[31:26];
    if (op == 6'b000000) return 3'd0;
    if (op[5:3] == 3'b010) return 3'd1;
    if (op[5:3] == 3'b011) return 3'd2;
    if (op[5:3] == 3'b100) return 3'd3;
    if (op[5:4] == 2'b11) return 3'd4;
    if (op[5:3] == 3'b101) return 3'd5;
    return 3'd6;
  endfunction

  function automatic logic [4:0] f_dst(logic [31:0] w);
    case (f_class(w))
      3'd3:       return w[15:11];
      3'd1, 3'd4: return w[20:16];
      default:    return 5'd0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] f_imm(logic [31:0] w);
    return {{(XLEN-16){w[15]}}, w[15:0]};
  endfunction

  function automatic logic [XLEN-1:0] f_read(logic [4:0] idx, logic we,
                                             logic [4:0] wa, logic [XLEN-1:0] wd);
    if (idx == 5'd0) return '0;
    if (we && wa == idx) return wd;
    return m_regs[idx];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    m_pc = '1;
    m_ir = '0;
  endtask

  // One cycle: inputs driven after a falling edge, combinational outputs
  // checked before the rising edge, registered state checked after it.
  task automatic step(logic [31:0] w, logic frz, logic we, logic [4:0] wa,
                      logic [XLEN-1:0] wd);
    logic [XLEN-1:0] ra;
    logic            tk;
    logic [PC_W-1:0] fa;
    instr_i = w; freeze = frz; wb_en = we; wb_idx = wa; wb_data = wd;
    #1;
    ra = f_read(m_ir[25:21], we, wa, wd);
    tk = (f_class(m_ir) == 3'd5) && (m_ir[26] ? (ra != '0) : (ra == '0));
    fa = tk ? PC_W'(m_pc + 1'b1 + f_imm(m_ir)[PC_W-1:0]) : PC_W'(m_pc + 1'b1);
    check("R3 class", 32'(id_class_o), 32'(f_class(m_ir)));
    check("R4 dst", 32'(id_dst_o), 32'(f_dst(m_ir)));
    check("R4 func", 32'(id_func_o), 32'(m_ir[10:0]));
    check("R5 imm", id_imm_o, f_imm(m_ir));
    check("R7 R8 rs1", id_rs1_val_o, ra);
    check("R7 R8 rs2", id_rs2_val_o, f_read(m_ir[20:16], we, wa, wd));
    check("R6 R10 taken", 32'(br_taken_o), 32'(tk));
    check("R2 R6 fetch", 32'(fetch_addr_o), 32'(fa));
    @(posedge clk);
    if (we && wa != 5'd0) m_regs[wa] = wd;
    if (!frz) begin
      m_pc = fa;
      m_ir = w;
    end
    @(negedge clk);
    check("R2 R6 R9 pc", 32'(pc_o), 32'(m_pc));
  endtask

  task automatic reset_check();
    check("R1 pc", 32'(pc_o), 32'hFFFF);
    check("R1 fetch", 32'(fetch_addr_o), 32'h0);
    check("R1 class", 32'(id_class_o), 32'h0);
    check("R1 taken", 32'(br_taken_o), 32'h0);
  endtask

  function automatic logic [31:0] rand_word();
    logic [5:0]  op;
    logic [31:0] w;
    case ($urandom_range(0, 7))
      0: op = 6'b000000;
      1: op = {3'b010, 3'($urandom)};
      2: op = {3'b011, 3'($urandom)};
      3: op = {3'b100, 3'($urandom)};
      4: op = {2'b11, 4'($urandom)};
      5, 6: op = {3'b101, 3'($urandom)};
      default: op = 6'($urandom);
    endcase
    w = $urandom;
    w[31:26] = op;
    w[25:21] = 5'($urandom_range(0, 5));
    w[20:16] = 5'($urandom_range(0, 5));
    return w;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    checks = 0; errors = 0; done = 0;
    instr_i = '0; freeze = 0; wb_en = 0; wb_idx = '0; wb_data = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    #1 reset_check();                          // R1
    @(negedge clk);
    rst_n = 1'b1;

    // R7: write to register 0 ignored, decode reads zero
    step({6'b100000, 5'd0, 5'd0, 5'd3, 11'h0}, 0, 1, 5'd0, 32'hDEADBEEF);
    step(32'h0, 0, 1, 5'd0, 32'h1234_5678);
    // R8: bypass into a non-zero branch test, then into a zero branch test
    step({6'b101001, 5'd4, 5'd0, 16'h0005}, 0, 0, 5'd0, '0);
    step(32'h0, 0, 1, 5'd4, 32'h0000_0042);
    step({6'b101000, 5'd4, 5'd0, 16'h0002}, 0, 0, 5'd0, '0);
    step(32'h0, 0, 1, 5'd4, 32'h0);
    // R10: backward jump on register 0, wrapping below address 0
    step({6'b101000, 5'd0, 5'd0, 16'hFFF0}, 0, 0, 5'd0, '0);
    step(32'h0, 0, 0, 5'd0, '0);
    // R9: frozen branch keeps state while write-back proceeds
    step({6'b101001, 5'd2, 5'd1, 16'h0010}, 0, 0, 5'd0, '0);
    step(32'hFFFF_FFFF, 1, 1, 5'd2, 32'h7);
    step(32'hFFFF_FFFF, 1, 0, 5'd0, '0);
    step(32'h0, 0, 0, 5'd0, '0);

    for (int n = 0; n < 3000; n++) begin
      logic [XLEN-1:0] d;
      d = ($urandom_range(0, 3) == 0) ? '0 : $urandom;
      step(rand_word(), ($urandom_range(0, 7) == 0), $urandom_range(0, 1) == 1,
           5'($urandom_range(0, 5)), d);
      if (n == 1500) begin
        rst_n = 1'b0;
        #1;
        model_reset();
        reset_check();                         // R1 mid-run
        @(negedge clk);
        rst_n = 1'b1;
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule